// File: doc/BRIEF.md
# Failure-Link Table Builder for Pattern Matching

This block takes a pattern of up to `MAX_LEN` characters that already sits in on-chip registers and derives its failure function: for every prefix length h from 2 to m, the length of the longest proper prefix of the pattern that is also a suffix of its first h characters. It does this by comparing the pattern against itself with a row index and a column index. When a comparison fails and the column is not zero, it falls back through links that it has already produced. The block reads the pattern through two combinational character-read ports, one addressed by the row index and one by the column index.

Each failure value becomes a back edge from state h to state pi[h]. The edge is written into an internal link table, which later comparisons read, and it is also reported on a link-write output for a downstream search engine. Each edge is also sent as a three-byte burst to a configuration-style byte-write port. Forming the insertion address takes one cycle, and each byte write takes one more. Comparisons pause until the burst has finished. A single `done_o` pulse marks the end of a run.

Top module: `kmp_link_builder`

## Requirements
- R1: After reset `done_o`, `lw_en_o` and `cw_en_o` are low, and they stay low until a start request is accepted.
- R2: A run with effective length m produces exactly one link write for each row h = 2..m, in ascending order of h. A run with m of 0 or 1 produces no link write and no byte write.
- R3: The column of the link write for row h equals the longest proper prefix of the pattern that is also a suffix of its first h characters, which is always smaller than h. This holds for patterns that need fallback through links built earlier in the same run.
- R4: The byte burst for an edge starts in the cycle after that edge's link write and occupies three consecutive cycles.
- R5: Each byte-write address carries `TAG` (default 2'b10) in bits 15:14, the row in bits 13:8, the byte index (0, 1, 2 in burst order) in bits 7:6 and the column in bits 5:0.
- R6: The three bytes of a burst are `INS_DATA` (default 24'hA5C33C), most significant byte first: A5, C3, 3C.
- R7: `done_o` is a one-cycle pulse and occurs exactly once per accepted start. It comes two cycles after the last byte write, or one cycle after the accepting edge when there are no edges.
- R8: A start request made while a run is in progress is ignored. The run's output and its single `done_o` pulse are unchanged.
- R9: A requested length above `MAX_LEN` is treated as `MAX_LEN`.
- R10: No comparison advances while a burst is in progress. Link writes and byte writes never share a cycle, and consecutive link writes are at least four cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| len_i | input | 7 | Requested pattern length |
| rd_i_idx_o | output | 6 | Character index for the row-side read |
| rd_i_chr_i | input | 8 | Pattern character at `rd_i_idx_o` |
| rd_q_idx_o | output | 6 | Character index for the column-side read |
| rd_q_chr_i | input | 8 | Pattern character at `rd_q_idx_o` |
| lw_en_o | output | 1 | Link-table write strobe |
| lw_row_o | output | 6 | Link row (prefix length h) |
| lw_col_o | output | 6 | Link column (pi[h]) |
| cw_en_o | output | 1 | Byte-write strobe |
| cw_addr_o | output | 16 | Byte-write address |
| cw_data_o | output | 8 | Byte-write data |
| done_o | output | 1 | End-of-run pulse |

## Verification
The hardest situation to reach is a chain of fallbacks, where a mismatch with a nonzero column reads a link written several edges earlier in the same run and then mismatches again. It can only be reached through the choice of pattern. The bench therefore uses runs of one repeated character ended by a different one, a pattern with nested borders ("aabaabaaab"), and the all-same 32-character pattern. It compares every link against a brute-force border computation in the bench. A start pulse with a different length in the middle of a long run, and an over-length request, cover the ignore rule and the clamp.

// File: rtl/kmp_pkg.sv
package kmp_pkg;

    localparam int IDX_W   = 6;
    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 2;
    localparam int TAG_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_POS,
        ST_WR0,
        ST_WR1,
        ST_WR2,
        ST_FIN
    } build_st_e;

    typedef struct packed {
        build_st_e          st;
        logic [IDX_W-1:0]   i;
        logic [IDX_W-1:0]   q;
        logic [IDX_W-1:0]   m;
        logic [IDX_W-1:0]   row;
        logic [IDX_W-1:0]   col;
        logic               lw_en;
        logic [ADDR_W-1:0]  base;
    } build_regs_t;

endpackage

// File: rtl/kmp_link_table.sv
module kmp_link_table #(
    parameter int DEPTH = 33,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [IW-1:0] rdata
);

    logic [IW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (we && (waddr < IW'(DEPTH))) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr < IW'(DEPTH)) rdata = mem_q[raddr];
    end

endmodule

// File: rtl/kmp_cmp_step.sv
module kmp_cmp_step #(
    parameter int IW = 6,
    parameter int CW = 8
) (
    input  logic [IW-1:0] i_cur,
    input  logic [IW-1:0] q_cur,
    input  logic [IW-1:0] link_of_q,
    input  logic [CW-1:0] chr_at_i,
    input  logic [CW-1:0] chr_at_q,
    output logic          record,
    output logic [IW-1:0] i_nxt,
    output logic [IW-1:0] q_nxt
);

    always_comb begin
        i_nxt  = i_cur;
        q_nxt  = q_cur;
        record = 1'b0;
        if (chr_at_i == chr_at_q) begin
            i_nxt  = i_cur + 1'b1;
            q_nxt  = q_cur + 1'b1;
            record = 1'b1;
        end else if (q_cur == '0) begin
            i_nxt  = i_cur + 1'b1;
            q_nxt  = '0;
            record = 1'b1;
        end else begin
            q_nxt  = link_of_q;
        end
    end

endmodule

// File: rtl/kmp_edge_packer.sv
module kmp_edge_packer
    import kmp_pkg::*;
#(
    parameter logic [TAG_W-1:0] TAG      = 2'b10,
    parameter int               DATA_W   = 24,
    parameter logic [DATA_W-1:0] INS_DATA = 24'hA5C33C
) (
    input  logic [IDX_W-1:0]  row,
    input  logic [IDX_W-1:0]  col,
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] base_addr,
    output logic [BYTE_W-1:0] byte_out
);

    localparam int NB = DATA_W / BYTE_W;

    logic [BYTE_W-1:0] bytes [NB];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign bytes[g] = INS_DATA[DATA_W-1-g*BYTE_W -: BYTE_W];
    end

    assign base_addr = {TAG, row, {SEL_W{1'b0}}, col};

    always_comb begin
        byte_out = '0;
        for (int k = 0; k < NB; k++) begin
            if (sel == SEL_W'(k)) byte_out = bytes[k];
        end
    end

endmodule

// File: rtl/kmp_link_builder.sv
module kmp_link_builder
    import kmp_pkg::*;
#(
    parameter int               CHAR_W   = 8,
    parameter int               MAX_LEN  = 32,
    parameter logic [TAG_W-1:0] TAG      = 2'b10,
    parameter logic [23:0]      INS_DATA = 24'hA5C33C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IDX_W:0]     len_i,
    output logic [IDX_W-1:0]   rd_i_idx_o,
    input  logic [CHAR_W-1:0]  rd_i_chr_i,
    output logic [IDX_W-1:0]   rd_q_idx_o,
    input  logic [CHAR_W-1:0]  rd_q_chr_i,
    output logic               lw_en_o,
    output logic [IDX_W-1:0]   lw_row_o,
    output logic [IDX_W-1:0]   lw_col_o,
    output logic               cw_en_o,
    output logic [ADDR_W-1:0]  cw_addr_o,
    output logic [BYTE_W-1:0]  cw_data_o,
    output logic               done_o
);

    localparam int TBL_DEPTH = MAX_LEN + 1;
    localparam logic [IDX_W:0]   LEN_CAP = (IDX_W+1)'(MAX_LEN);

    build_regs_t r_q, r_d;

    logic [IDX_W-1:0]  link_rd;
    logic              step_rec;
    logic [IDX_W-1:0]  step_i, step_q;
    logic [SEL_W-1:0]  byte_sel;
    logic [ADDR_W-1:0] pk_base;
    logic [BYTE_W-1:0] pk_byte;

    kmp_link_table #(
        .DEPTH (TBL_DEPTH),
        .IW    (IDX_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (r_q.lw_en),
        .waddr (r_q.row),
        .wdata (r_q.col),
        .raddr (r_q.q),
        .rdata (link_rd)
    );

    kmp_cmp_step #(
        .IW (IDX_W),
        .CW (CHAR_W)
    ) u_step (
        .i_cur     (r_q.i),
        .q_cur     (r_q.q),
        .link_of_q (link_rd),
        .chr_at_i  (rd_i_chr_i),
        .chr_at_q  (rd_q_chr_i),
        .record    (step_rec),
        .i_nxt     (step_i),
        .q_nxt     (step_q)
    );

    kmp_edge_packer #(
        .TAG      (TAG),
        .DATA_W   (24),
        .INS_DATA (INS_DATA)
    ) u_pack (
        .row       (r_q.row),
        .col       (r_q.col),
        .sel       (byte_sel),
        .base_addr (pk_base),
        .byte_out  (pk_byte)
    );

    always_comb begin
        unique case (r_q.st)
            ST_WR1:  byte_sel = 2'd1;
            ST_WR2:  byte_sel = 2'd2;
            default: byte_sel = 2'd0;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.lw_en = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.m  = (len_i > LEN_CAP) ? IDX_W'(MAX_LEN) : len_i[IDX_W-1:0];
                    r_d.i  = IDX_W'(1);
                    r_d.q  = '0;
                    r_d.st = ST_CMP;
                end
            end
            ST_CMP: begin
                if (r_q.i >= r_q.m) begin
                    r_d.st = ST_FIN;
                end else if (step_rec) begin
                    r_d.i     = step_i;
                    r_d.q     = step_q;
                    r_d.row   = step_i;
                    r_d.col   = step_q;
                    r_d.lw_en = 1'b1;
                    r_d.st    = ST_POS;
                end else begin
                    r_d.q = step_q;
                end
            end
            ST_POS: begin
                r_d.base = pk_base;
                r_d.st   = ST_WR0;
            end
            ST_WR0:  r_d.st = ST_WR1;
            ST_WR1:  r_d.st = ST_WR2;
            ST_WR2:  r_d.st = ST_CMP;
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_i_idx_o = r_q.i;
    assign rd_q_idx_o = r_q.q;
    assign lw_en_o    = r_q.lw_en;
    assign lw_row_o   = r_q.row;
    assign lw_col_o   = r_q.col;
    assign cw_en_o    = (r_q.st == ST_WR0) || (r_q.st == ST_WR1) || (r_q.st == ST_WR2);
    assign cw_addr_o  = {r_q.base[ADDR_W-1:8], byte_sel, r_q.base[5:0]};
    assign cw_data_o  = pk_byte;
    assign done_o     = (r_q.st == ST_FIN);

endmodule

// File: rtl/kmp_link_builder_chk.sv
module kmp_link_builder_chk
    import kmp_pkg::*;
#(
    parameter logic [TAG_W-1:0] TAG_VAL = 2'b10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lw_en_o,
    input logic [IDX_W-1:0]  lw_row_o,
    input logic [IDX_W-1:0]  lw_col_o,
    input logic              cw_en_o,
    input logic [ADDR_W-1:0] cw_addr_o,
    input logic              done_o
);

    assert_burst_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en_o |=> (cw_en_o && cw_addr_o[7:6] == 2'd0));

    assert_burst_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en_o && cw_addr_o[7:6] == 2'd0) |=> (cw_en_o && cw_addr_o[7:6] == 2'd1));

    assert_burst_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en_o && cw_addr_o[7:6] == 2'd1) |=> (cw_en_o && cw_addr_o[7:6] == 2'd2));

    assert_tag_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cw_en_o |-> (cw_addr_o[15:14] == TAG_VAL));

    assert_addr_follows_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en_o |=> (cw_addr_o[13:8] == $past(lw_row_o) && cw_addr_o[5:0] == $past(lw_col_o)));

    assert_back_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en_o |-> (lw_col_o < lw_row_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cw_en_o |-> !lw_en_o);

    assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lw_en_o |=> !lw_en_o);

endmodule

bind kmp_link_builder kmp_link_builder_chk #(.TAG_VAL(TAG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lw_en_o   (lw_en_o),
    .lw_row_o  (lw_row_o),
    .lw_col_o  (lw_col_o),
    .cw_en_o   (cw_en_o),
    .cw_addr_o (cw_addr_o),
    .done_o    (done_o)
);

// File: tb/sim_kmp_link_builder.sv
module sim_kmp_link_builder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  len_i = '0;
    logic [5:0]  rd_i_idx, rd_q_idx;
    logic [7:0]  rd_i_chr, rd_q_chr;
    logic        lw_en, cw_en, done;
    logic [5:0]  lw_row, lw_col;
    logic [15:0] cw_addr;
    logic [7:0]  cw_data;

    logic [7:0]  pat [64];

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    int lw_n, cw_n, done_n, done_cyc;
    int lw_r [64];
    int lw_c [64];
    int lw_t [64];
    int cw_a [200];
    int cw_d [200];
    int cw_t [200];

    always #5 clk = ~clk;

    assign rd_i_chr = pat[rd_i_idx];
    assign rd_q_chr = pat[rd_q_idx];

    kmp_link_builder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .len_i      (len_i),
        .rd_i_idx_o (rd_i_idx),
        .rd_i_chr_i (rd_i_chr),
        .rd_q_idx_o (rd_q_idx),
        .rd_q_chr_i (rd_q_chr),
        .lw_en_o    (lw_en),
        .lw_row_o   (lw_row),
        .lw_col_o   (lw_col),
        .cw_en_o    (cw_en),
        .cw_addr_o  (cw_addr),
        .cw_data_o  (cw_data),
        .done_o     (done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (lw_en && lw_n < 64) begin
            lw_r[lw_n] = lw_row; lw_c[lw_n] = lw_col; lw_t[lw_n] = cyc; lw_n++;
        end
        if (cw_en && cw_n < 200) begin
            cw_a[cw_n] = cw_addr; cw_d[cw_n] = cw_data; cw_t[cw_n] = cyc; cw_n++;
        end
        if (done) begin
            done_n++; done_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input string s);
        for (int k = 0; k < 64; k++) pat[k] = 8'h00;
        for (int k = 0; k < s.len() && k < 64; k++) pat[k] = s[k];
    endtask

    function automatic int ref_border(input int h);
        for (int k = h - 1; k >= 1; k--) begin
            bit eq = 1'b1;
            for (int t = 0; t < k; t++)
                if (pat[t] != pat[h - k + t]) eq = 1'b0;
            if (eq) return k;
        end
        return 0;
    endfunction

    task automatic run_case(input string nm, input int len, input bit interfere);
        int meff, s_cyc, wait_n, nexp, byte_exp;
        int bytes_ref [3];
        bytes_ref[0] = 8'hA5; bytes_ref[1] = 8'hC3; bytes_ref[2] = 8'h3C;
        meff = (len > 32) ? 32 : len;
        nexp = (meff > 1) ? meff - 1 : 0;
        @(posedge clk); #1;
        lw_n = 0; cw_n = 0; done_n = 0; done_cyc = -1;
        @(negedge clk);
        start_i = 1'b1; len_i = 7'(len);
        @(negedge clk);
        start_i = 1'b0;
        s_cyc = cyc;
        if (interfere) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; len_i = 7'd3;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_n = 0;
        while (done_n == 0 && wait_n < 5000) begin
            @(negedge clk); wait_n++;
        end
        repeat (20) @(negedge clk);
        $display("[TB] case %s len %0d", nm, len);
        // R2 / R9 / R8: number of link writes
        check(lw_n == nexp, "R2 link count", lw_n, nexp);
        for (int j = 0; j < lw_n && j < nexp; j++) begin
            check(lw_r[j] == j + 2, "R2 row order", lw_r[j], j + 2);
            check(lw_c[j] == ref_border(j + 2), "R3 border value", lw_c[j], ref_border(j + 2));
            if (j > 0) check(lw_t[j] - lw_t[j-1] >= 4, "R10 stall spacing", lw_t[j] - lw_t[j-1], 4);
        end
        check(cw_n == 3 * lw_n, "R4 byte write count", cw_n, 3 * lw_n);
        for (int j = 0; j < lw_n && 3 * j + 2 < cw_n; j++) begin
            for (int b = 0; b < 3; b++) begin
                check(cw_t[3*j+b] == lw_t[j] + 1 + b, "R4 burst timing", cw_t[3*j+b], lw_t[j] + 1 + b);
                check(cw_a[3*j+b] == ((2 << 14) | (lw_r[j] << 8) | (b << 6) | lw_c[j]),
                      "R5 address", cw_a[3*j+b], (2 << 14) | (lw_r[j] << 8) | (b << 6) | lw_c[j]);
                byte_exp = bytes_ref[b];
                check(cw_d[3*j+b] == byte_exp, "R6 data byte", cw_d[3*j+b], byte_exp);
            end
        end
        check(done_n == 1, "R7 single done", done_n, 1);
        if (cw_n > 0)
            check(done_cyc == cw_t[cw_n-1] + 2, "R7 done timing", done_cyc, cw_t[cw_n-1] + 2);
        else
            check(done_cyc == s_cyc + 1, "R7 done timing short", done_cyc, s_cyc + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        load("");
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done at reset", done, 0);
        check(lw_en == 1'b0, "R1 link strobe at reset", lw_en, 0);
        check(cw_en == 1'b0, "R1 byte strobe at reset", cw_en, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(done == 1'b0 && lw_en == 1'b0 && cw_en == 1'b0, "R1 idle after reset", done | lw_en | cw_en, 0);

        load("ababca");       run_case("mixed borders R3", 6, 1'b0);
        load("aaaaab");       run_case("worst case fallback R3", 6, 1'b0);
        load("aabaabaaab");   run_case("nested borders R3", 10, 1'b0);
        load("abcdefgh");     run_case("no borders R2", 8, 1'b0);
        load("ab");           run_case("two chars R2", 2, 1'b0);
        load("a");            run_case("length one R2 R7", 1, 1'b0);
        load("");             run_case("length zero R2 R7", 0, 1'b0);
        load("aaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaa");
        run_case("all same max R3", 32, 1'b0);
        load("abaababaabaababaababaabaababaabab");
        run_case("ignored start R8", 20, 1'b1);
        load("abcabcabdabcabcabdabcabcabdxyzabcabcab");
        run_case("clamped length R9", 40, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule